// File: doc/BRIEF.md
# Strobe-Handshake Register Bank with Retimed Readback

This block is a bank of software-visible 32-bit registers behind a single-beat request/acknowledge handshake. The requester raises `req` for one cycle with a write flag, a byte address and, for writes, the data. A purely combinational decoder turns the address into one select line per register. Writes land in the addressed register at the next clock edge and are acknowledged in the request cycle itself. Every register's current value is driven out on a flat hardware-side vector.

Reads do not use a multiplexer. Each register is gated by its own select line and all the gated words are OR-combined into one read word. Two parameters can each add a pipeline register on that path. One sits in the middle of the OR tree, between the lower-half and upper-half partial results. The other sits on the final response. The read latency is therefore 0, 1 or 2 cycles. Writes always take zero cycles, so the requester must not issue a write while a read response is still in flight. Apart from that rule, one request per cycle may be issued, and responses come back in request order.

Top module: `strobe_regfile`

## Requirements
- R1: The address is a byte address and registers are 4 bytes apart. Register k is selected by address bits [ADDR_W-1:2] equal to k. Address bits [1:0] are ignored.
- R2: A write request raises `wr_ack` in the same cycle with `wr_err` = 0. From the next cycle, the addressed register shows the new data on `hw_out[k*32 +: 32]`.
- R3: A read request raises `rd_ack` for exactly one cycle, LAT = FANIN_RETIME + RESP_RETIME cycles after the request cycle (2 by default). `rd_data` in that cycle holds the value the register had when the request was sampled.
- R4: A read whose index is NUM_REGS or higher is still acknowledged, with `rd_data` = 0 and `rd_err` = 0.
- R5: `rd_err` is always 0. `rd_data` is 0 in every cycle without `rd_ack`.
- R6: Reads issued on consecutive cycles are acknowledged on consecutive cycles, in issue order, each with its own data.
- R7: A synchronous active-high `rst` clears all registers to 0 and cancels any read in flight, so no `rd_ack` follows for it.
- R8: A write to an index of NUM_REGS or higher changes no register.
- R9: `rd_ack` and `wr_ack` are never high in the same cycle, provided no write is issued within LAT cycles after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid for this cycle |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data |
| rd_ack | output | 1 | Read completion strobe |
| rd_err | output | 1 | Read error, qualified by rd_ack |
| rd_data | output | DATA_W | Read data, qualified by rd_ack |
| wr_ack | output | 1 | Write completion strobe |
| wr_err | output | 1 | Write error, qualified by wr_ack |
| hw_out | output | NUM_REGS*DATA_W | All register values, register k at bits k*DATA_W upward |

## Verification
Some properties are checked on every cycle. These are the error flags being zero, read data being zero when there is no acknowledge, the two acknowledges never coinciding, each read acknowledge tracing back to a read request exactly LAT cycles earlier, and no acknowledge right after reset. Other properties need scenarios from the bench. These are that the right register is selected for a given address, including the ignored low bits and indices outside the bank; that a write is visible on the hardware vector one cycle later; that back-to-back reads return in order with the right data; and that a read cut off by reset never completes.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Total read latency implied by the two optional retiming stages.
  function automatic int read_latency(input int fanin_rt, input int resp_rt);
    return ((fanin_rt != 0) ? 1 : 0) + ((resp_rt != 0) ? 1 : 0);
  endfunction
endpackage

// File: rtl/regfile_decode.sv
module regfile_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             unused_byte_lane;

  assign word_idx         = addr[ADDR_W-1:2];
  assign unused_byte_lane = ^addr[1:0];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel[k] = req && (word_idx == IDX_W'(k));
  end
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS-1:0]        wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_sel[k]) begin
        val_q <= wr_data;
      end
    end
    assign regs_flat[k*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/regfile_readback.sv
module regfile_readback #(
  parameter int DATA_W       = 32,
  parameter int NUM_REGS     = 16,
  parameter int FANIN_RETIME = 1,
  parameter int RESP_RETIME  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  logic [NUM_REGS-1:0]        rd_sel,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic                       rd_ack,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int HALF = NUM_REGS / 2;

  logic [DATA_W-1:0] part_lo, part_hi;
  logic [DATA_W-1:0] lo_a, hi_a;
  logic              vld_a;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] data_b;
  logic              vld_b;

  // Gate each register with its select, reduce each half separately.
  always_comb begin
    part_lo = '0;
    part_hi = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel[k]) begin
        if (k < HALF) part_lo = part_lo | regs_flat[k*DATA_W +: DATA_W];
        else          part_hi = part_hi | regs_flat[k*DATA_W +: DATA_W];
      end
    end
  end

  if (FANIN_RETIME != 0) begin : g_fanin
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_a  <= '0;
        hi_a  <= '0;
        vld_a <= 1'b0;
      end else begin
        lo_a  <= part_lo;
        hi_a  <= part_hi;
        vld_a <= rd_req;
      end
    end
  end else begin : g_fanin_bypass
    assign lo_a  = part_lo;
    assign hi_a  = part_hi;
    assign vld_a = rd_req;
  end

  assign merged = lo_a | hi_a;

  if (RESP_RETIME != 0) begin : g_resp
    always_ff @(posedge clk) begin
      if (rst) begin
        data_b <= '0;
        vld_b  <= 1'b0;
      end else begin
        data_b <= merged;
        vld_b  <= vld_a;
      end
    end
  end else begin : g_resp_bypass
    assign data_b = merged;
    assign vld_b  = vld_a;
  end

  assign rd_ack  = vld_b;
  assign rd_data = data_b;
endmodule

// File: rtl/strobe_regfile.sv
module strobe_regfile #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int NUM_REGS     = 16,
  parameter int FANIN_RETIME = 1,
  parameter int RESP_RETIME  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic                       req_is_wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       rd_ack,
  output logic                       rd_err,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       wr_ack,
  output logic                       wr_err,
  output logic [NUM_REGS*DATA_W-1:0] hw_out
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;

  regfile_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .req  (req),
    .addr (addr),
    .sel  (sel)
  );

  assign wr_sel = req_is_wr ? sel : '0;
  assign rd_sel = req_is_wr ? '0  : sel;

  regfile_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .regs_flat (hw_out)
  );

  regfile_readback #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .FANIN_RETIME(FANIN_RETIME), .RESP_RETIME(RESP_RETIME)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (req && !req_is_wr),
    .rd_sel    (rd_sel),
    .regs_flat (hw_out),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data)
  );

  assign rd_err = 1'b0;
  assign wr_ack = req && req_is_wr;
  assign wr_err = 1'b0;
endmodule

// File: rtl/strobe_regfile_chk.sv
module strobe_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int LAT    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              req_is_wr,
  input logic              rd_ack,
  input logic              rd_err,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_ack,
  input logic              wr_err
);
  // R2
  wr_err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> !wr_err);

  // R5
  rd_err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> !rd_err);

  // R5
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> (rd_data == '0));

  // R9
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_ack && wr_ack));

  if (LAT == 0) begin : g_l0
    // R3
    rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> (req && !req_is_wr));
  end else if (LAT == 1) begin : g_l1
    // R3
    rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> $past(req && !req_is_wr));
    // R7
    rst_flush_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rd_ack);
  end else begin : g_l2
    // R3
    rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> $past(req && !req_is_wr, 2));
    // R7
    rst_flush_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rd_ack);
  end
endmodule

bind strobe_regfile strobe_regfile_chk #(
  .DATA_W (DATA_W),
  .LAT    (regfile_pkg::read_latency(FANIN_RETIME, RESP_RETIME))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .req_is_wr (req_is_wr),
  .rd_ack    (rd_ack),
  .rd_err    (rd_err),
  .rd_data   (rd_data),
  .wr_ack    (wr_ack),
  .wr_err    (wr_err)
);

// File: tb/strobe_regfile_tb.sv
module strobe_regfile_tb;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int NR  = 16;
  localparam int FRT = 1;
  localparam int RRT = 1;
  localparam int LAT = FRT + RRT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_is_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_ack, rd_err, wr_ack, wr_err;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] hw_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [DW-1:0] shadow [NR];

  always #4 clk = ~clk;

  strobe_regfile #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR),
                   .FANIN_RETIME(FRT), .RESP_RETIME(RRT)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_is_wr(req_is_wr), .addr(addr),
    .wr_data(wr_data), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .hw_out(hw_out)
  );

  // {is_wr, addr, wdata, expected read}
  localparam logic [72:0] VEC [10] = '{
    {1'b1, 8'h00, 32'hA5A5_0001, 32'h0},
    {1'b1, 8'h3C, 32'h1234_5678, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'hA5A5_0001},
    {1'b0, 8'h3C, 32'h0,         32'h1234_5678},
    {1'b1, 8'h05, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'hDEAD_BEEF},
    {1'b0, 8'h40, 32'h0,         32'h0},
    {1'b1, 8'h80, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0},
    {1'b0, 8'h07, 32'h0,         32'hDEAD_BEEF}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int j = 0; j < NR; j++)
      check(hw_out[j*DW +: DW] === shadow[j], tag, hw_out[j*DW +: DW], shadow[j]);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    int idx;
    @(negedge clk);
    req = 1'b1; req_is_wr = 1'b1; addr = a; wr_data = d;
    #1;
    check(wr_ack === 1'b1, "R2 wr_ack", DW'(wr_ack), 1);
    check(wr_err === 1'b0, "R2 wr_err", DW'(wr_err), 0);
    check(rd_ack === 1'b0, "R9 no rd_ack", DW'(rd_ack), 0);
    @(negedge clk);
    req = 1'b0; req_is_wr = 1'b0;
    idx = int'(a >> 2);
    if (idx < NR) shadow[idx] = d;
    #1;
    check_regs(tag);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    for (int c = 0; c <= LAT + 1; c++) begin
      @(negedge clk);
      if (c == 0) begin req = 1'b1; req_is_wr = 1'b0; addr = a; end
      else req = 1'b0;
      #1;
      if (c == LAT) begin
        check(rd_ack === 1'b1, {tag, " ack"}, DW'(rd_ack), 1);
        check(rd_data === exp, {tag, " data"}, rd_data, exp);
        check(rd_err === 1'b0, "R5 rd_err", DW'(rd_err), 0);
      end else begin
        check(rd_ack === 1'b0, "R3 single-cycle ack", DW'(rd_ack), 0);
        check(rd_data === '0, "R5 idle data", rd_data, 0);
      end
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NR; j++) shadow[j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // reset state (R7)
    check_regs("R7 reset regs");
    check(rd_ack === 1'b0, "R7 reset rd_ack", DW'(rd_ack), 0);
    check(wr_ack === 1'b0, "R7 reset wr_ack", DW'(wr_ack), 0);

    // vector table walk (R1 R2 R3 R4 R8)
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][72]) do_write(VEC[v][71:64], VEC[v][63:32], "R1/R2/R8 write");
      else            do_read (VEC[v][71:64], VEC[v][31:0],  "R1/R3/R4 read");
    end

    // R6: three back-to-back reads, acks in order
    begin
      logic [AW-1:0] pa [3];
      logic [DW-1:0] pe [3];
      pa[0] = 8'h00; pe[0] = 32'hA5A5_0001;
      pa[1] = 8'h3C; pe[1] = 32'h1234_5678;
      pa[2] = 8'h04; pe[2] = 32'hDEAD_BEEF;
      for (int c = 0; c <= LAT + 3; c++) begin
        @(negedge clk);
        if (c < 3) begin req = 1'b1; req_is_wr = 1'b0; addr = pa[c]; end
        else req = 1'b0;
        #1;
        if (c >= LAT && c - LAT < 3) begin
          check(rd_ack === 1'b1, "R6 pipelined ack", DW'(rd_ack), 1);
          check(rd_data === pe[c-LAT], "R6 pipelined data", rd_data, pe[c-LAT]);
        end else begin
          check(rd_ack === 1'b0, "R6 no extra ack", DW'(rd_ack), 0);
        end
      end
    end

    // R7: reset cancels a read in flight and clears registers
    @(negedge clk);
    req = 1'b1; req_is_wr = 1'b0; addr = 8'h00;
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < NR; j++) shadow[j] = '0;
    for (int c = 0; c < LAT + 2; c++) begin
      #1;
      check(rd_ack === 1'b0, "R7 flushed read", DW'(rd_ack), 0);
      @(negedge clk);
    end
    check_regs("R7 regs cleared");
    do_read(8'h3C, 32'h0, "R7 read after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule